// File: doc/BRIEF.md
# Cascaded CAM Match/Full Flag Chain Node

This block is the per-device arbitration logic that sits beside one content-addressable memory device when several devices are stacked in a vertical chain. When a compare finishes, the device's array reports three local flags: hit, multiple hit and full. The node holds these flags and shows the hit and multiple-hit flags unchanged on their own pins. It also forwards two separate chained flags to the next device. The chained match says that this device or some device above it matched. The chained room says that this device or some device above it still has a free slot.

From its own flags and the chain inputs, the node works out whether this device owns the system's highest-priority match and whether it owns the system's next free slot. For every bus cycle it uses these two facts, plus the system-wide match flag fed back from the last device, to decide two things: whether this device drives the shared data bus, and whether it accepts a write. At most one device answers for a given read. Reads of memory and of ordinary registers are refused on every device when nothing in the system matched. A read of the next-free register is still allowed in that case.

The chain inputs of the first device are tied to 0. The chained match output of the last device is the system match flag. The system is full when the last device's chained room output is low.

Top module: `cam_cascade_node`

## Requirements
- R1: A compare strobe (`cmp_i`=1) captures `hit_i`, `multi_i` and `full_i` at the clock edge. `int_match_o` and `int_multi_o` then show the captured hit and multiple-hit flags with no chain qualification. All captured flags are 0 after reset.
- R2: A context switch (`ctx_sw_i`=1) clears the captured hit and multiple-hit flags at the next edge. It wins over a compare strobe in the same cycle. The captured full flag is still loaded by that compare strobe, and it is left unchanged when no compare strobe is present.
- R3: `dn_match_o` is 1 when `up_match_i` is 1 or the captured hit flag is 1. It does not depend on the full flags.
- R4: `dn_room_o` is 1 when `up_room_i` is 1 or the captured full flag is 0. `chain_full_o` is its inverse, so it is 1 only when this device and every earlier device are full. It does not depend on the match flags.
- R5: A status read (`op_kind_i`=3) sets `bus_drive_o` on the next cycle only when the captured hit flag is 1 and `up_match_i` is 0. This is the match owner.
- R6: A memory read (`op_kind_i`=0) or register read (`op_kind_i`=1) while `sys_match_i`=0 leaves `bus_drive_o` at 0 on the next cycle on every device.
- R7: A next-free register read (`op_kind_i`=2) sets `bus_drive_o` on the next cycle only when the captured full flag is 0 and `up_room_i` is 0. This is the free-slot owner. `sys_match_i` has no effect on it.
- R8: A memory or register read while `sys_match_i`=1 is driven next cycle by the free-slot owner when `op_tgt_i`=2. For any other target value it is driven by the match owner.
- R9: A command write (`op_kind_i`=4) or data write (`op_kind_i`=5) sets `take_write_o` on the next cycle. With `op_tgt_i`=1 only the match owner takes it. With `op_tgt_i`=2 only the free-slot owner takes it. With `op_tgt_i`=0 or 3 every device takes it.
- R10: With `op_valid_i`=0, or with `op_kind_i` of 6 or 7, both `bus_drive_o` and `take_write_o` are 0 on the next cycle. Reads never set `take_write_o`, and writes never set `bus_drive_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Compare result strobe from the local array |
| hit_i | input | 1 | Local array hit |
| multi_i | input | 1 | Local array multiple hit |
| full_i | input | 1 | Local array full |
| ctx_sw_i | input | 1 | Active register set changed; clears match state |
| up_match_i | input | 1 | Some earlier device matched (0 on first device) |
| up_room_i | input | 1 | Some earlier device has a free slot (0 on first device) |
| sys_match_i | input | 1 | System match, the last device's `dn_match_o` |
| op_valid_i | input | 1 | Bus cycle present |
| op_kind_i | input | 3 | Cycle kind: 0 mem read, 1 reg read, 2 next-free read, 3 status read, 4 cmd write, 5 data write |
| op_tgt_i | input | 2 | Address target: 0 any, 1 top match, 2 next free, 3 any |
| int_match_o | output | 1 | Unqualified local match |
| int_multi_o | output | 1 | Unqualified local multiple match |
| dn_match_o | output | 1 | Chained match to next device |
| dn_room_o | output | 1 | Chained room to next device |
| chain_full_o | output | 1 | This and all earlier devices full |
| bus_drive_o | output | 1 | This device drives the data bus for the cycle |
| take_write_o | output | 1 | This device accepts the write |

## Verification
The hardest situation to reach is one where match ownership and free-slot ownership sit on different devices of a four-deep chain. A further case is where several devices hit at once, so that a later device with a valid local hit must still stay silent. The bench builds these from compare patterns in which the upper devices are full and several lower ones hit. It then cycles through every read and write kind against each target. Context switches, alone and together with a compare, clear the hits while the full flags stay in place. This exposes the system-wide refusal of reads while next-free reads keep working.

// File: rtl/cas_pkg.sv
package cas_pkg;
    localparam int OPK_W = 3;
    localparam int TGT_W = 2;

    typedef enum logic [OPK_W-1:0] {
        OPK_RD_MEM    = 3'd0,
        OPK_RD_REG    = 3'd1,
        OPK_RD_NFREE  = 3'd2,
        OPK_RD_STATUS = 3'd3,
        OPK_WR_CMD    = 3'd4,
        OPK_WR_DATA   = 3'd5,
        OPK_RSV6      = 3'd6,
        OPK_RSV7      = 3'd7
    } opk_e;

    typedef enum logic [TGT_W-1:0] {
        TGT_ANY  = 2'd0,
        TGT_TOP  = 2'd1,
        TGT_FREE = 2'd2,
        TGT_ANY3 = 2'd3
    } tgt_e;

    typedef struct packed {
        logic match;
        logic multi;
        logic full;
    } flags_t;

    typedef struct packed {
        logic drive;
        logic take;
    } resp_t;
endpackage

// File: rtl/cas_flag_store.sv
module cas_flag_store
    import cas_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cmp_i,
    input  logic   hit_i,
    input  logic   multi_i,
    input  logic   full_i,
    input  logic   ctx_i,
    output flags_t flags_o
);
    flags_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (cmp_i) begin
            flags_d.match = hit_i;
            flags_d.multi = multi_i;
            flags_d.full  = full_i;
        end
        if (ctx_i) begin
            flags_d.match = 1'b0;
            flags_d.multi = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    assert_ctx_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_i |=> (!flags_q.match && !flags_q.multi));

    assert_full_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_i) |=> $stable(flags_q.full));

    assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_i && !ctx_i) |=> (flags_q.match == $past(hit_i)));
endmodule

// File: rtl/cas_chain_link.sv
module cas_chain_link (
    input  logic up_match_i,
    input  logic up_room_i,
    input  logic loc_match_i,
    input  logic loc_full_i,
    output logic dn_match_o,
    output logic dn_room_o,
    output logic own_match_o,
    output logic own_free_o
);
    always_comb begin
        dn_match_o  = up_match_i | loc_match_i;
        dn_room_o   = up_room_i | ~loc_full_i;
        own_match_o = loc_match_i & ~up_match_i;
        own_free_o  = ~loc_full_i & ~up_room_i;
    end
endmodule

// File: rtl/cas_resp_gate.sv
module cas_resp_gate
    import cas_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid_i,
    input  logic [OPK_W-1:0] op_kind_i,
    input  logic [TGT_W-1:0] op_tgt_i,
    input  logic             own_match_i,
    input  logic             own_free_i,
    input  logic             sys_match_i,
    output logic             drive_o,
    output logic             take_o
);
    resp_t resp_d, resp_q;
    opk_e  kind;
    tgt_e  tgt;

    always_comb begin
        kind   = opk_e'(op_kind_i);
        tgt    = tgt_e'(op_tgt_i);
        resp_d = '0;
        if (op_valid_i) begin
            unique case (kind)
                OPK_RD_STATUS: resp_d.drive = own_match_i;
                OPK_RD_NFREE:  resp_d.drive = own_free_i;
                OPK_RD_MEM, OPK_RD_REG: begin
                    if (sys_match_i)
                        resp_d.drive = (tgt == TGT_FREE) ? own_free_i : own_match_i;
                end
                OPK_WR_CMD, OPK_WR_DATA: begin
                    if (tgt == TGT_TOP)       resp_d.take = own_match_i;
                    else if (tgt == TGT_FREE) resp_d.take = own_free_i;
                    else                      resp_d.take = 1'b1;
                end
                default: resp_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign drive_o = resp_q.drive;
    assign take_o  = resp_q.take;

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> (!drive_o && !take_o));

    assert_no_drive_unmatched_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && (op_kind_i == 3'd0 || op_kind_i == 3'd1) && !sys_match_i) |=> !drive_o);

    assert_status_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_kind_i == 3'd3 && !own_match_i) |=> !drive_o);

    assert_targeted_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_kind_i >= 3'd4 && op_kind_i <= 3'd5 && op_tgt_i == 2'd1 && !own_match_i) |=> !take_o);

    assert_one_role_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_o && take_o));
endmodule

// File: rtl/cam_cascade_node.sv
module cam_cascade_node
    import cas_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_i,
    input  logic             hit_i,
    input  logic             multi_i,
    input  logic             full_i,
    input  logic             ctx_sw_i,
    input  logic             up_match_i,
    input  logic             up_room_i,
    input  logic             sys_match_i,
    input  logic             op_valid_i,
    input  logic [OPK_W-1:0] op_kind_i,
    input  logic [TGT_W-1:0] op_tgt_i,
    output logic             int_match_o,
    output logic             int_multi_o,
    output logic             dn_match_o,
    output logic             dn_room_o,
    output logic             chain_full_o,
    output logic             bus_drive_o,
    output logic             take_write_o
);
    flags_t flags;
    logic   own_match, own_free;

    cas_flag_store u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_i   (cmp_i),
        .hit_i   (hit_i),
        .multi_i (multi_i),
        .full_i  (full_i),
        .ctx_i   (ctx_sw_i),
        .flags_o (flags)
    );

    cas_chain_link u_link (
        .up_match_i  (up_match_i),
        .up_room_i   (up_room_i),
        .loc_match_i (flags.match),
        .loc_full_i  (flags.full),
        .dn_match_o  (dn_match_o),
        .dn_room_o   (dn_room_o),
        .own_match_o (own_match),
        .own_free_o  (own_free)
    );

    cas_resp_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid_i  (op_valid_i),
        .op_kind_i   (op_kind_i),
        .op_tgt_i    (op_tgt_i),
        .own_match_i (own_match),
        .own_free_i  (own_free),
        .sys_match_i (sys_match_i),
        .drive_o     (bus_drive_o),
        .take_o      (take_write_o)
    );

    assign int_match_o  = flags.match;
    assign int_multi_o  = flags.multi;
    assign chain_full_o = ~dn_room_o;

    assert_match_chain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        up_match_i |-> dn_match_o);

    assert_room_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        up_room_i |-> !chain_full_o);

    assert_full_needs_local_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chain_full_o |-> !up_room_i);
endmodule

// File: tb/sim_cam_cascade_node.sv
`timescale 1ns/1ps
module sim_cam_cascade_node;
    localparam int ND = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [ND-1:0] hit = '0, mul = '0, ful = '0;
    logic cmp = 1'b0, ctx = 1'b0, ov = 1'b0;
    logic [2:0] ok = 3'd0;
    logic [1:0] ot = 2'd0;

    logic [ND-1:0] w_im, w_imu, w_dm, w_dr, w_cf, w_bd, w_tw, w_um, w_ur;
    logic sys_m;
    assign sys_m = w_dm[ND-1];

    for (genvar i = 0; i < ND; i++) begin : g_dev
        if (i == 0) begin : g_first
            assign w_um[i] = 1'b0;
            assign w_ur[i] = 1'b0;
        end else begin : g_rest
            assign w_um[i] = w_dm[i-1];
            assign w_ur[i] = w_dr[i-1];
        end
        cam_cascade_node u0 (
            .clk(clk), .rst_n(rst_n), .cmp_i(cmp), .hit_i(hit[i]), .multi_i(mul[i]),
            .full_i(ful[i]), .ctx_sw_i(ctx), .up_match_i(w_um[i]), .up_room_i(w_ur[i]),
            .sys_match_i(sys_m), .op_valid_i(ov), .op_kind_i(ok), .op_tgt_i(ot),
            .int_match_o(w_im[i]), .int_multi_o(w_imu[i]), .dn_match_o(w_dm[i]),
            .dn_room_o(w_dr[i]), .chain_full_o(w_cf[i]), .bus_drive_o(w_bd[i]),
            .take_write_o(w_tw[i])
        );
    end

    int tests = 0, fails = 0;
    bit done = 0;
    bit lm[ND], lmu[ND], lf[ND];
    bit ex_drv[ND], ex_tak[ND];
    string tag_rsp = "R10";

    task automatic chk(input logic act, input logic exp, input string tag, input string what, input int dev);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s dev%0d %s: actual %0b expected %0b", tag, dev, what, act, exp);
        end
    endtask

    // Behavioural reference: walk the chain from the top device down.
    task automatic predict();
        bit any_m, any_r, own_m, own_f;
        int k;
        any_m = 0; any_r = 0;
        for (int d = 0; d < ND; d++) if (lm[d]) any_m = 1;
        k = int'(ok);
        if (!ov || k > 5)               tag_rsp = "R10";
        else if (k == 3)                tag_rsp = "R5";
        else if (k == 2)                tag_rsp = "R7";
        else if (k <= 1 && !any_m)      tag_rsp = "R6";
        else if (k <= 1)                tag_rsp = "R8";
        else                            tag_rsp = "R9";
        begin
            bit seen_m, seen_r;
            seen_m = 0; seen_r = 0;
            for (int d = 0; d < ND; d++) begin
                own_m = lm[d] && !seen_m;
                own_f = !lf[d] && !seen_r;
                ex_drv[d] = 0; ex_tak[d] = 0;
                if (ov) begin
                    if (k == 3) ex_drv[d] = own_m;
                    else if (k == 2) ex_drv[d] = own_f;
                    else if (k <= 1) ex_drv[d] = any_m && ((ot == 2'd2) ? own_f : own_m);
                    else if (k <= 5) ex_tak[d] = (ot == 2'd1) ? own_m : (ot == 2'd2) ? own_f : 1'b1;
                end
                if (lm[d]) seen_m = 1;
                if (!lf[d]) seen_r = 1;
            end
        end
    endtask

    task automatic compare_all();
        bit up_m, up_r;
        up_m = 0; up_r = 0;
        for (int d = 0; d < ND; d++) begin
            chk(w_im[d], lm[d], "R1", "int_match", d);
            chk(w_imu[d], lmu[d], "R1", "int_multi", d);
            chk(w_dm[d], up_m | lm[d], "R3", "dn_match", d);
            chk(w_dr[d], up_r | !lf[d], "R4", "dn_room", d);
            chk(w_cf[d], !(up_r | !lf[d]), "R4", "chain_full", d);
            chk(w_bd[d], ex_drv[d], tag_rsp, "bus_drive", d);
            chk(w_tw[d], ex_tak[d], tag_rsp, "take_write", d);
            up_m = up_m | lm[d];
            up_r = up_r | !lf[d];
        end
    endtask

    task automatic step();
        predict();
        @(posedge clk);
        for (int d = 0; d < ND; d++) begin
            if (cmp) begin lm[d] = hit[d]; lmu[d] = mul[d]; lf[d] = ful[d]; end
            if (ctx) begin lm[d] = 0; lmu[d] = 0; end
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_cmp(input logic [ND-1:0] h, input logic [ND-1:0] m, input logic [ND-1:0] f, input logic c);
        hit = h; mul = m; ful = f; cmp = 1'b1; ctx = c; ov = 1'b0;
        step();
        cmp = 1'b0; ctx = 1'b0;
    endtask

    task automatic do_op(input int k, input int t);
        ov = 1'b1; ok = 3'(k); ot = 2'(t);
        step();
        ov = 1'b0;
    endtask

    task automatic sweep_ops();
        for (int k = 0; k < 8; k++)
            for (int t = 0; t < 4; t++) do_op(k, t);
        step();
    endtask

    initial begin
        for (int d = 0; d < ND; d++) begin lm[d] = 0; lmu[d] = 0; lf[d] = 0; ex_drv[d] = 0; ex_tak[d] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();                              // reset state: R1, R10
        step();                                     // idle: R10
        do_cmp(4'b1010, 4'b1000, 4'b0011, 0);       // hits on dev1,dev3; dev0,1 full
        sweep_ops();                                // R5 R7 R8 R9 R10
        do_cmp(4'b1111, 4'b0110, 4'b0000, 0);       // all hit: only dev0 owns
        sweep_ops();
        ctx = 1'b1; step(); ctx = 1'b0;             // R2 context switch clears match
        sweep_ops();                                // R6 denial, R7 next-free still served
        do_cmp(4'b0100, 4'b0100, 4'b1111, 0);       // all full, hit on dev2
        sweep_ops();                                // R4 system full; no free owner
        do_cmp(4'b1001, 4'b1001, 4'b0111, 1);       // R2 ctx beats compare, full loaded
        sweep_ops();
        do_cmp(4'b0001, 4'b0000, 4'b1110, 0);       // match and free both on dev0
        sweep_ops();
        for (int n = 0; n < 400; n++) begin
            hit = 4'($urandom); mul = 4'($urandom) & hit; ful = 4'($urandom);
            cmp = 1'($urandom); ctx = ($urandom % 8) == 0;
            ov = 1'($urandom); ok = 3'($urandom); ot = 2'($urandom);
            step();
        end
        cmp = 0; ctx = 0; ov = 0;
        step();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule